// File: doc/BRIEF.md
# Pulse Width and Period Capture Unit

This block times a digital waveform arriving on one of two input pins. After it is armed, a qualifying edge on the chosen pin starts a small wrapping counter. A later qualifying edge captures the elapsed time. Which edges qualify depends on the measurement kind (high/low width, full cycle, or both) and on the polarity setting.

The counter wraps at a programmable length. Each wrap is tallied in a short overflow register, so a captured value covers many wraps: it equals the wrap tally times the wrap length, plus the counter value at the capture. In both-kind mode the first capture is held as the width and the second closes the cycle, so both values are reported with one strobe.

Each measurement runs either once, after which the unit disarms itself, or repeatedly, with the start edge restarting the counter. The pins are asynchronous and are synchronised inside the block. Configuration is latched when the unit is armed.

Top module: `pcap_unit`

## Requirements
- R1: The pin measured is `pin_b` when `pin_sel`=1 and `pin_a` when `pin_sel`=0; edges on the other pin have no effect, and the counter stays at 0 while awaiting the start edge.
- R2: With `invert`=0 the start edge is a rising edge; with `invert`=1 it is a falling edge. Once the start edge arrives, `timer_count` leaves 0.
- R3: With `meas_type`=2 (cycle), the capture edge is the same kind as the start edge. `res_period` holds the clock cycles between the two edges and `res_pulse` reads 0.
- R4: With `meas_type`=1 (width), the capture edge is the opposite kind to the start edge. `res_pulse` holds the cycles between them and `res_period` reads 0.
- R5: With `meas_type`=3 (both), captures are taken on either edge. The first capture after the start is the width and the second is the cycle. Both are reported together with a single `res_valid` strobe.
- R6: A result equals the overflow tally times the wrap length, plus the counter value. The wrap length is `period_len`, with 0 meaning 2^CW, and it must be at least 2.
- R7: The overflow tally saturates at 2^OW-1 instead of wrapping.
- R8: With `continuous`=1 the unit stays armed and reports every cycle. A start edge that coincides with a completed result restarts the counter at once.
- R9: With `continuous`=0 the unit disarms itself: `active` falls in the same cycle that `res_valid` is high.
- R10: A capture taken while the counter reads 0 is ignored. No result is produced and the unit stays armed.
- R11: Arming while `active` is high is refused with a one-cycle `busy_err` strobe, and the measurement in progress continues.
- R12: Arming with `meas_type`=0 is refused with a one-cycle `inval_err` strobe, and the unit stays idle.
- R13: `disarm` clears the counter to 0 and drops `active` on the next cycle. It strobes `cancel` if the unit was armed. It takes priority over `arm`.
- R14: After reset the unit is idle, with all outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_a | input | 1 | Asynchronous waveform input A |
| pin_b | input | 1 | Asynchronous waveform input B |
| pin_sel | input | 1 | Pin choice, latched at arm (1 = B) |
| meas_type | input | 2 | 0 none, 1 width, 2 cycle, 3 both; latched at arm |
| invert | input | 1 | Polarity, latched at arm |
| continuous | input | 1 | Repeat mode, latched at arm |
| period_len | input | CW | Counter wrap length (0 = 2^CW) |
| arm | input | 1 | One-cycle request to start measuring |
| disarm | input | 1 | One-cycle request to stop and clear |
| active | output | 1 | Unit armed |
| timer_count | output | CW | Current counter value |
| res_valid | output | 1 | One-cycle result strobe |
| res_period | output | CW+OW | Measured cycle length in clocks |
| res_pulse | output | CW+OW | Measured width in clocks |
| busy_err | output | 1 | Arm refused: already active |
| inval_err | output | 1 | Arm refused: no measurement kind |
| cancel | output | 1 | Armed unit was stopped by disarm |

## Verification
A table of waveforms is run through every measurement kind on both pins and both polarities, with unequal high and low times. A width result that is wrongly taken on the starting edge, or a swapped polarity, therefore gives a different number. Some entries span several counter wraps or use short wrap lengths, which separates a correct overflow scaling from a plain counter reading. Directed cases drive long gaps that saturate the overflow tally, spacing that lands the counter exactly on 0 at capture, repeated cycles in continuous mode, toggling on the unselected pin, and refused arm requests.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
  typedef enum logic [1:0] {
    MT_NONE   = 2'd0,
    MT_PULSE  = 2'd1,
    MT_PERIOD = 2'd2,
    MT_BOTH   = 2'd3
  } meas_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } cap_st_t;
endpackage

// File: rtl/pcap_sync.sv
module pcap_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  // Two metastability flops, then one history flop per pin for edge detection.
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic m1_q, m2_q, m3_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m1_q <= 1'b0;
        m2_q <= 1'b0;
        m3_q <= 1'b0;
      end else begin
        m1_q <= pin_i[g];
        m2_q <= m1_q;
        m3_q <= m2_q;
      end
    end
    assign rise_o[g] = m2_q & ~m3_q;
    assign fall_o[g] = ~m2_q & m3_q;
  end
endmodule

// File: rtl/pcap_edge_sel.sv
module pcap_edge_sel
  import pcap_pkg::*;
(
  input  logic [1:0] rise_i,
  input  logic [1:0] fall_i,
  input  logic       sel_i,
  input  logic       inv_i,
  input  meas_t      mtype_i,
  output logic       start_o,
  output logic       cap_o
);
  logic r, f, opp;

  always_comb begin
    r       = rise_i[sel_i];
    f       = fall_i[sel_i];
    start_o = inv_i ? f : r;
    opp     = inv_i ? r : f;
    case (mtype_i)
      MT_PERIOD: cap_o = start_o;
      MT_PULSE:  cap_o = opp;
      MT_BOTH:   cap_o = r | f;
      default:   cap_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pcap_timer.sv
module pcap_timer #(
  parameter int CW = 8,
  parameter int OW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic          run_i,
  input  logic          ovf_clr_i,
  input  logic [CW-1:0] per_len_i,
  output logic [CW-1:0] cnt_o,
  output logic [OW-1:0] ovf_o
);
  logic [CW-1:0] cnt_q, cnt_n, wrap_at;
  logic [OW-1:0] ovf_q, ovf_n;

  assign wrap_at = per_len_i - CW'(1);

  always_comb begin
    cnt_n = cnt_q;
    ovf_n = ovf_q;
    if (clr_i) begin
      cnt_n = '0;
      ovf_n = '0;
    end else if (load_i) begin
      cnt_n = CW'(1);
      ovf_n = '0;
    end else begin
      if (ovf_clr_i) ovf_n = '0;
      if (run_i) begin
        if (cnt_q == wrap_at) begin
          cnt_n = '0;
          if (ovf_q != '1) ovf_n = ovf_q + OW'(1);
        end else begin
          cnt_n = cnt_q + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      ovf_q <= ovf_n;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/pcap_unit.sv
module pcap_unit
  import pcap_pkg::*;
#(
  parameter int CW = 8,
  parameter int OW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pin_a,
  input  logic            pin_b,
  input  logic            pin_sel,
  input  logic [1:0]      meas_type,
  input  logic            invert,
  input  logic            continuous,
  input  logic [CW-1:0]   period_len,
  input  logic            arm,
  input  logic            disarm,
  output logic            active,
  output logic [CW-1:0]   timer_count,
  output logic            res_valid,
  output logic [CW+OW-1:0] res_period,
  output logic [CW+OW-1:0] res_pulse,
  output logic            busy_err,
  output logic            inval_err,
  output logic            cancel
);
  localparam int RW = CW + OW;

  // Reset: asserted asynchronously, released on the clock.
  logic rst_m_q, rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_i_n <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_i_n <= rst_m_q;
    end
  end

  cap_st_t       st_q, st_n;
  meas_t         mtype_q, mtype_n;
  logic          sel_q, sel_n, inv_q, inv_n, cont_q, cont_n, half_q, half_n;
  logic [RW-1:0] pend_q, pend_n, per_q, per_n, pul_q, pul_n;
  logic          valid_q, valid_n, busy_q, busy_n, inval_q, inval_n, cancel_q, cancel_n;
  logic          t_clr, t_load, t_run, t_oclr, done, running;
  logic [1:0]    rise, fall;
  logic          start_ev, cap_ev;
  logic [CW-1:0] cnt;
  logic [OW-1:0] ovf;
  logic [CW:0]   per_full;
  logic [RW-1:0] cap_val;

  pcap_sync #(.N(2)) u_sync (
    .clk(clk), .rst_n(rst_i_n), .pin_i({pin_b, pin_a}), .rise_o(rise), .fall_o(fall)
  );

  pcap_edge_sel u_esel (
    .rise_i(rise), .fall_i(fall), .sel_i(sel_q), .inv_i(inv_q),
    .mtype_i(mtype_q), .start_o(start_ev), .cap_o(cap_ev)
  );

  pcap_timer #(.CW(CW), .OW(OW)) u_timer (
    .clk(clk), .rst_n(rst_i_n), .clr_i(t_clr), .load_i(t_load), .run_i(t_run),
    .ovf_clr_i(t_oclr), .per_len_i(period_len), .cnt_o(cnt), .ovf_o(ovf)
  );

  assign running  = (st_q == ST_RUN);
  assign per_full = {(period_len == '0), period_len};
  assign cap_val  = RW'(ovf) * RW'(per_full) + RW'(cnt);

  always_comb begin
    st_n = st_q;  mtype_n = mtype_q; sel_n = sel_q; inv_n = inv_q; cont_n = cont_q;
    half_n = half_q; pend_n = pend_q; per_n = per_q; pul_n = pul_q;
    valid_n = 1'b0; busy_n = 1'b0; inval_n = 1'b0; cancel_n = 1'b0;
    t_clr = 1'b0; t_load = 1'b0; t_run = running; t_oclr = 1'b0; done = 1'b0;
    if (disarm) begin
      st_n     = ST_IDLE;
      t_clr    = 1'b1;
      t_run    = 1'b0;
      half_n   = 1'b0;
      cancel_n = (st_q != ST_IDLE);
    end else if (arm && st_q == ST_IDLE) begin
      if (meas_t'(meas_type) == MT_NONE) begin
        inval_n = 1'b1;
      end else begin
        st_n    = ST_WAIT;
        mtype_n = meas_t'(meas_type);
        sel_n   = pin_sel;
        inv_n   = invert;
        cont_n  = continuous;
        half_n  = 1'b0;
        t_clr   = 1'b1;
      end
    end else begin
      busy_n = arm;
      case (st_q)
        ST_WAIT: begin
          if (start_ev) begin
            st_n   = ST_RUN;
            t_load = 1'b1;
          end
        end
        ST_RUN: begin
          if (cap_ev && cnt != '0) begin
            case (mtype_q)
              MT_PULSE:  begin pul_n = cap_val; per_n = '0; done = 1'b1; end
              MT_PERIOD: begin per_n = cap_val; pul_n = '0; done = 1'b1; end
              default: begin
                if (!half_q) begin
                  pend_n = cap_val;
                  half_n = 1'b1;
                end else begin
                  per_n  = cap_val;
                  pul_n  = pend_q;
                  half_n = 1'b0;
                  done   = 1'b1;
                end
              end
            endcase
            if (done) begin
              valid_n = 1'b1;
              if (!cont_q) begin
                st_n  = ST_IDLE;
                t_clr = 1'b1;
                t_run = 1'b0;
              end else if (start_ev) begin
                t_load = 1'b1;
              end else begin
                st_n   = ST_WAIT;
                t_run  = 1'b0;
                t_oclr = 1'b1;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q <= ST_IDLE;  mtype_q <= MT_NONE; sel_q <= 1'b0; inv_q <= 1'b0; cont_q <= 1'b0;
      half_q <= 1'b0;   pend_q <= '0; per_q <= '0; pul_q <= '0;
      valid_q <= 1'b0;  busy_q <= 1'b0; inval_q <= 1'b0; cancel_q <= 1'b0;
    end else begin
      st_q <= st_n;     mtype_q <= mtype_n; sel_q <= sel_n; inv_q <= inv_n; cont_q <= cont_n;
      half_q <= half_n; pend_q <= pend_n; per_q <= per_n; pul_q <= pul_n;
      valid_q <= valid_n; busy_q <= busy_n; inval_q <= inval_n; cancel_q <= cancel_n;
    end
  end

  assign active      = (st_q != ST_IDLE);
  assign timer_count = cnt;
  assign res_valid   = valid_q;
  assign res_period  = per_q;
  assign res_pulse   = pul_q;
  assign busy_err    = busy_q;
  assign inval_err   = inval_q;
  assign cancel      = cancel_q;
endmodule

// File: rtl/pcap_unit_chk.sv
module pcap_unit_chk #(
  parameter int CW = 8,
  parameter int OW = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm,
  input logic             disarm,
  input logic [1:0]       meas_type,
  input logic             active,
  input logic [CW-1:0]    timer_count,
  input logic             res_valid,
  input logic [CW+OW-1:0] res_period,
  input logic [CW+OW-1:0] res_pulse,
  input logic             busy_err,
  input logic             inval_err,
  input logic             running,
  input logic             cap_ev,
  input logic             cont_q,
  input logic [1:0]       mtype_q
);
  // R13: disarm leaves a cleared, inactive unit
  p_disarm_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
    disarm |=> (timer_count == '0 && !active));

  // R11: arming an active unit is refused
  p_busy_reject_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && active && !disarm) |=> busy_err);

  // R12: arming without a measurement kind is refused
  p_invalid_reject_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !active && !disarm && meas_type == 2'd0) |=> (inval_err && !active));

  // R9: single mode drops active together with the result strobe
  p_single_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !cont_q) |-> !active);

  // R10: a capture at counter value zero gives no result
  p_zero_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cap_ev && timer_count == '0 && !disarm) |=> !res_valid);

  // R4: width-only results carry no cycle length
  p_pulse_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && mtype_q == 2'd1) |-> res_period == '0);

  // R3: cycle-only results carry no width
  p_period_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && mtype_q == 2'd2) |-> res_pulse == '0);
endmodule

bind pcap_unit pcap_unit_chk #(.CW(CW), .OW(OW)) i_chk (
  .clk(clk), .rst_n(rst_i_n), .arm(arm), .disarm(disarm), .meas_type(meas_type),
  .active(active), .timer_count(timer_count), .res_valid(res_valid),
  .res_period(res_period), .res_pulse(res_pulse), .busy_err(busy_err),
  .inval_err(inval_err), .running(running), .cap_ev(cap_ev), .cont_q(cont_q),
  .mtype_q(mtype_q)
);

// File: tb/test_pcap_unit.sv
`timescale 1ns/1ps
module test_pcap_unit;
  localparam int CW = 8;
  localparam int OW = 4;
  localparam int RW = CW + OW;
  localparam int NV = 6;

  // {sel, invert, kind[1:0], first phase[11:0], second phase[11:0], wrap length[7:0]}
  localparam logic [35:0] VEC [NV] = '{
    {1'b0, 1'b0, 2'd1, 12'd20,  12'd30,  8'd0},
    {1'b0, 1'b0, 2'd2, 12'd20,  12'd30,  8'd0},
    {1'b1, 1'b1, 2'd3, 12'd25,  12'd15,  8'd0},
    {1'b1, 1'b0, 2'd3, 12'd300, 12'd100, 8'd0},
    {1'b0, 1'b1, 2'd2, 12'd7,   12'd9,   8'd5},
    {1'b0, 1'b0, 2'd3, 12'd13,  12'd22,  8'd10}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic [1:0] pins = 2'b00;
  logic pin_sel = 1'b0, invert = 1'b0, continuous = 1'b0, arm = 1'b0, disarm = 1'b0;
  logic [1:0] meas_type = 2'd0;
  logic [CW-1:0] period_len = '0;
  logic active, res_valid, busy_err, inval_err, cancel;
  logic [CW-1:0] timer_count;
  logic [RW-1:0] res_period, res_pulse;

  int n_chk = 0, n_fail = 0;
  int vcnt = 0, bcnt = 0, icnt = 0, ccnt = 0;
  int lat_per = 0, lat_pul = 0;

  always #10 clk = ~clk;

  pcap_unit #(.CW(CW), .OW(OW)) i_pcap_unit (
    .clk(clk), .rst_n(rst_n), .pin_a(pins[0]), .pin_b(pins[1]), .pin_sel(pin_sel),
    .meas_type(meas_type), .invert(invert), .continuous(continuous),
    .period_len(period_len), .arm(arm), .disarm(disarm), .active(active),
    .timer_count(timer_count), .res_valid(res_valid), .res_period(res_period),
    .res_pulse(res_pulse), .busy_err(busy_err), .inval_err(inval_err), .cancel(cancel)
  );

  always @(negedge clk) begin
    if (res_valid) begin
      vcnt++;
      lat_per = int'(res_period);
      lat_pul = int'(res_pulse);
    end
    if (busy_err)  bcnt++;
    if (inval_err) icnt++;
    if (cancel)    ccnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_arm();
    @(negedge clk) arm = 1'b1;
    @(negedge clk) arm = 1'b0;
  endtask

  task automatic pulse_disarm();
    @(negedge clk) disarm = 1'b1;
    @(negedge clk) disarm = 1'b0;
  endtask

  task automatic setup(input logic s, input logic iv, input logic [1:0] t,
                       input logic c, input logic [CW-1:0] pl);
    @(negedge clk);
    pin_sel = s; invert = iv; meas_type = t; continuous = c; period_len = pl;
    pins = 2'b00;
    pins[s] = iv;
    idle(6);
  endtask

  task automatic run_vec(input logic [35:0] v);
    int p1, p2, base, ep, eu;
    logic s, iv;
    logic [1:0] t;
    string req;
    s = v[35]; iv = v[34]; t = v[33:32];
    p1 = int'(v[31:20]); p2 = int'(v[19:8]);
    setup(s, iv, t, 1'b0, v[7:0]);
    pulse_arm();
    idle(4);
    base = vcnt;
    pins[s] = ~iv; idle(p1);
    pins[s] = iv;  idle(p2);
    pins[s] = ~iv; idle(p1);
    pins[s] = iv;  idle(8);
    case (t)
      2'd1:    begin ep = 0;       eu = p1; req = "R4"; end
      2'd2:    begin ep = p1 + p2; eu = 0;  req = "R3"; end
      default: begin ep = p1 + p2; eu = p1; req = "R5"; end
    endcase
    if (iv) req = {req, "/R2"};
    if (s) req = {req, "/R1"};
    if (v[7:0] != 0 || p1 + p2 > 255) req = {req, "/R6"};
    chk({req, " result count"}, vcnt - base, 1);
    chk({req, " period"}, lat_per, ep);
    chk({req, " pulse"}, lat_pul, eu);
    chk("R9 single disarms", int'(active), 0);
  endtask

  initial begin
    int base;
    #1 rst_n = 1'b0;
    idle(4);
    chk("R14 active", int'(active), 0);
    chk("R14 valid", int'(res_valid), 0);
    chk("R14 count", int'(timer_count), 0);
    chk("R14 period", int'(res_period), 0);
    @(negedge clk) rst_n = 1'b1;
    idle(4);
    chk("R14 after release", int'(active), 0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R12: arm with no kind
    setup(1'b0, 1'b0, 2'd0, 1'b0, 8'd0);
    base = icnt;
    pulse_arm(); idle(2);
    chk("R12 invalid strobe", icnt - base, 1);
    chk("R12 stays idle", int'(active), 0);

    // R1: unselected pin ignored while waiting for a start edge
    setup(1'b0, 1'b0, 2'd2, 1'b0, 8'd0);
    pulse_arm(); idle(4);
    base = vcnt;
    repeat (3) begin pins[1] = 1'b1; idle(5); pins[1] = 1'b0; idle(5); end
    chk("R1 other pin count", int'(timer_count), 0);
    chk("R1 other pin armed", int'(active), 1);
    chk("R1 other pin no result", vcnt - base, 0);
    // R2: rising edge on selected pin starts counting
    pins[0] = 1'b1; idle(6);
    chk("R2 counter started", int'(timer_count != 0), 1);
    // R11: arm while active
    base = bcnt;
    pulse_arm(); idle(2);
    chk("R11 busy strobe", bcnt - base, 1);
    chk("R11 still armed", int'(active), 1);
    // R13: disarm
    base = ccnt;
    pulse_disarm(); idle(1);
    chk("R13 cancel strobe", ccnt - base, 1);
    chk("R13 count cleared", int'(timer_count), 0);
    chk("R13 inactive", int'(active), 0);

    // R7: overflow tally saturates (gap 101, wrap 4 -> 15*4+1)
    setup(1'b0, 1'b0, 2'd2, 1'b0, 8'd4);
    pulse_arm(); idle(4);
    base = vcnt;
    pins[0] = 1'b1; idle(50); pins[0] = 1'b0; idle(51); pins[0] = 1'b1; idle(8);
    chk("R7 result count", vcnt - base, 1);
    chk("R7 saturated period", lat_per, 61);

    // R10: capture landing on counter value 0 (gap 16, wrap 8)
    setup(1'b0, 1'b0, 2'd2, 1'b0, 8'd8);
    pulse_arm(); idle(4);
    base = vcnt;
    pins[0] = 1'b1; idle(8); pins[0] = 1'b0; idle(8); pins[0] = 1'b1; idle(8);
    chk("R10 no result", vcnt - base, 0);
    chk("R10 still armed", int'(active), 1);
    pulse_disarm(); idle(2);

    // R8: continuous cycle measurement
    setup(1'b0, 1'b0, 2'd2, 1'b1, 8'd0);
    pulse_arm(); idle(4);
    base = vcnt;
    repeat (3) begin pins[0] = 1'b1; idle(10); pins[0] = 1'b0; idle(20); end
    idle(6);
    chk("R8 cycle results", vcnt - base, 2);
    chk("R8 cycle value", lat_per, 30);
    chk("R8 stays armed", int'(active), 1);
    pulse_disarm(); idle(2);

    // R8: continuous width measurement
    setup(1'b0, 1'b0, 2'd1, 1'b1, 8'd0);
    pulse_arm(); idle(4);
    base = vcnt;
    repeat (2) begin pins[0] = 1'b1; idle(12); pins[0] = 1'b0; idle(20); end
    idle(6);
    chk("R8 width results", vcnt - base, 2);
    chk("R8 width value", lat_pul, 12);
    chk("R8 width armed", int'(active), 1);
    pulse_disarm(); idle(2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule